// File: doc/BRIEF.md
# Counter-Mode Payload Encryptor with Integrity-Code Masking

This block turns a plaintext payload into ciphertext by counter-mode keystream generation and hides a 64-bit integrity value under the first keystream block. A frame starts with a handshake that carries a 128-bit initial counter block and the 64-bit integrity value. The block sends that counter block to an external block-cipher port. Every cipher call uses the single session key held by that external core. The upper half of the returned keystream is XORed into the integrity value, and the result leaves first on the output channel.

The block then steps the counter and requests one keystream block for each payload block. Each payload block is XORed with its own keystream block. The payload need not fill a whole number of 16-byte blocks. The last block carries a count of valid bytes, the unused bytes come out as zero, and no padding is added.

Only one cipher request is outstanding at a time. Each payload block is accepted only once its keystream is ready. A `done` pulse closes the frame. Forming the initial counter block, the receive direction and the cipher itself sit outside this block.

Top module: `ctr_mic_encryptor`

## Requirements
- R1: After reset `start_ready` is 1, and `out_valid`, `ciph_req_valid`, `pl_ready` and `done` are 0.
- R2: The first cipher request after a start handshake carries the initial counter block A0 unchanged.
- R3: The first output of a frame has `out_is_mic`=1 and `out_nbytes`=8. Its `out_data[63:0]` equals the integrity value XORed with bits [127:64] of the keystream returned for A0, and `out_data[127:64]` is zero.
- R4: Cipher request k of a frame (k=0 for A0) carries A0 with bits [15:0] replaced by (A0[15:0]+k) mod 65536. Bits [127:16] do not change.
- R5: Ciphertext block j (j=1 for the first payload block) equals payload block j XORed with the keystream returned for request j. It has `out_is_mic`=0.
- R6: Byte k of a block occupies bits [127-8k:120-8k]. On the last payload block a `pl_nbytes` value n in 1..15 forces output bytes k>=n to zero and gives `out_nbytes`=n. A value of 0 or 16 or more, and every non-last block, counts as 16 full bytes.
- R7: A frame of N payload blocks issues exactly N+1 cipher requests. No new request is issued while a response is pending.
- R8: `out_last` is 1 only on the ciphertext of the last payload block. `done` pulses for one cycle in the cycle after that block's output handshake, and the block then returns to idle.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output fields hold steady. While a cipher request waits for `ciph_req_ready`, the request block holds steady.
- R10: `start_ready` is 0 from the start handshake until the frame ends. A start request raised during a frame has no effect on that frame's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Frame start request |
| start_ready | output | 1 | Idle, a start can be taken |
| start_ctr | input | 128 | Initial counter block A0 |
| start_mic | input | 64 | Integrity value to be masked |
| pl_valid | input | 1 | Payload block offered |
| pl_ready | output | 1 | Payload block can be taken |
| pl_data | input | 128 | Payload block, byte 0 in the top bits |
| pl_last | input | 1 | Marks the final payload block |
| pl_nbytes | input | 5 | Valid byte count of the final block |
| ciph_req_valid | output | 1 | Cipher request pending |
| ciph_req_ready | input | 1 | Cipher accepts the request |
| ciph_req_block | output | 128 | Counter block to encrypt |
| ciph_rsp_valid | input | 1 | Cipher result present |
| ciph_rsp_block | input | 128 | Keystream block |
| out_valid | output | 1 | Output item valid |
| out_ready | input | 1 | Output item taken |
| out_data | output | 128 | Masked value or ciphertext |
| out_is_mic | output | 1 | Item is the masked integrity value |
| out_last | output | 1 | Item is the final ciphertext block |
| out_nbytes | output | 5 | Meaningful bytes in the item |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Two functions can meet in one cycle: the wrap of the 16-bit counter field and the final partial-block mask. Directed frames start with A0[15:0] at 0xFFFE or 0xFFFF, so the last block or the one before it runs on a wrapped counter while a short byte count is applied. Random frames also hit the wrap. The bench then judges every cipher request against its own counter formula and every ciphertext byte against its own shifted mask. The cipher stub and the output consumer stall at random, and a stray start request is raised during some frames, so hold-steady and ignore behaviour are tested under backpressure.

// File: rtl/ctr_mic_pkg.sv
package ctr_mic_pkg;
  localparam int BLK_W = 128;
  localparam int MIC_W = 64;
  localparam int BYTES = BLK_W / 8;
  localparam int NB_W  = $clog2(BYTES) + 1;

  typedef logic [BLK_W-1:0] blk_t;
  typedef logic [MIC_W-1:0] mic_t;
  typedef logic [NB_W-1:0]  nb_t;

  typedef enum logic [1:0] {T_IDLE, T_KS, T_PL, T_OUT} top_st_e;
  typedef enum logic [1:0] {P_IDLE, P_REQ, P_WAIT} port_st_e;

  // Step the counter field (low 'bits' bits), carry out of the field is dropped.
  function automatic blk_t ctr_step(blk_t b, int unsigned bits);
    blk_t m;
    m = '1;
    m = m >> (BLK_W - bits);
    return (b & ~m) | (blk_t'(b + blk_t'(1)) & m);
  endfunction

  // Mask with all-ones bytes for positions below nb; byte 0 is the top byte.
  function automatic blk_t keep_mask(nb_t nb);
    blk_t m;
    m = '0;
    for (int k = 0; k < BYTES; k++) begin
      if (k < int'(nb)) m[BLK_W-1-8*k -: 8] = 8'hFF;
    end
    return m;
  endfunction

  function automatic nb_t norm_nbytes(logic last, nb_t nb);
    if (!last || nb == '0 || int'(nb) > BYTES) return nb_t'(BYTES);
    return nb;
  endfunction

  function automatic mic_t mic_mask(mic_t t, blk_t s);
    return t ^ s[BLK_W-1 -: MIC_W];
  endfunction
endpackage

// File: rtl/ctr_counter_reg.sv
module ctr_counter_reg
  import ctr_mic_pkg::*;
#(
  parameter int CTR_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  blk_t load_val,
  input  logic step,
  output blk_t ctr,
  output blk_t ctr_next
);
  blk_t ctr_q;

  always_comb begin
    if (load)      ctr_next = load_val;
    else if (step) ctr_next = ctr_step(ctr_q, CTR_BITS);
    else           ctr_next = ctr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctr_q <= '0;
    else        ctr_q <= ctr_next;
  end

  assign ctr = ctr_q;

  assert_ctr_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ctr[BLK_W-1:CTR_BITS] == $past(ctr[BLK_W-1:CTR_BITS]));

  assert_ctr_field_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ctr[CTR_BITS-1:0] == CTR_BITS'($past(ctr[CTR_BITS-1:0]) + 1'b1));
endmodule

// File: rtl/ctr_cipher_port.sv
module ctr_cipher_port
  import ctr_mic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  blk_t issue_blk,
  output logic idle,
  output logic req_valid,
  input  logic req_ready,
  output blk_t req_block,
  input  logic rsp_valid,
  input  blk_t rsp_block,
  output logic ks_fire,
  output blk_t ks
);
  port_st_e st_q;
  blk_t     req_q;
  blk_t     ks_q;
  logic     fire_q;
  logic     req_fire;
  logic     rsp_take;

  assign idle      = (st_q == P_IDLE);
  assign req_valid = (st_q == P_REQ);
  assign req_block = req_q;
  assign req_fire  = req_valid && req_ready;
  assign rsp_take  = (st_q == P_WAIT) && rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= P_IDLE;
      req_q  <= '0;
      ks_q   <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= rsp_take;
      case (st_q)
        P_IDLE: if (issue) begin
          req_q <= issue_blk;
          st_q  <= P_REQ;
        end
        P_REQ: if (req_fire) st_q <= P_WAIT;
        P_WAIT: if (rsp_take) begin
          ks_q <= rsp_block;
          st_q <= P_IDLE;
        end
        default: st_q <= P_IDLE;
      endcase
    end
  end

  assign ks_fire = fire_q;
  assign ks      = ks_q;

  assert_issue_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> idle);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_block)));

  assert_ks_after_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ks_fire |-> $past(rsp_valid));
endmodule

// File: rtl/ctr_out_stage.sv
module ctr_out_stage
  import ctr_mic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  blk_t d_data,
  input  logic d_mic,
  input  logic d_last,
  input  nb_t  d_nb,
  output logic out_valid,
  input  logic out_ready,
  output blk_t out_data,
  output logic out_is_mic,
  output logic out_last,
  output nb_t  out_nbytes,
  output logic fire
);
  logic v_q, mic_q, last_q;
  blk_t data_q;
  nb_t  nb_q;

  assign fire = v_q && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      data_q <= '0;
      mic_q  <= 1'b0;
      last_q <= 1'b0;
      nb_q   <= '0;
    end else if (load) begin
      v_q    <= 1'b1;
      data_q <= d_data;
      mic_q  <= d_mic;
      last_q <= d_last;
      nb_q   <= d_nb;
    end else if (fire) begin
      v_q <= 1'b0;
    end
  end

  assign out_valid  = v_q;
  assign out_data   = data_q;
  assign out_is_mic = mic_q;
  assign out_last   = last_q;
  assign out_nbytes = nb_q;

  assert_no_load_over_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_is_mic) && $stable(out_last) && $stable(out_nbytes)));

  assert_mic_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_mic) |-> (out_data[BLK_W-1:MIC_W] == '0 && !out_last));
endmodule

// File: rtl/ctr_mic_encryptor.sv
module ctr_mic_encryptor
  import ctr_mic_pkg::*;
#(
  parameter int CTR_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [BLK_W-1:0]  start_ctr,
  input  logic [MIC_W-1:0]  start_mic,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [BLK_W-1:0]  pl_data,
  input  logic              pl_last,
  input  logic [NB_W-1:0]   pl_nbytes,
  output logic              ciph_req_valid,
  input  logic              ciph_req_ready,
  output logic [BLK_W-1:0]  ciph_req_block,
  input  logic              ciph_rsp_valid,
  input  logic [BLK_W-1:0]  ciph_rsp_block,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BLK_W-1:0]  out_data,
  output logic              out_is_mic,
  output logic              out_last,
  output logic [NB_W-1:0]   out_nbytes,
  output logic              done
);
  localparam nb_t MIC_NB = nb_t'(MIC_W / 8);

  top_st_e st_q;
  mic_t    mic_q;
  logic    mic_phase_q;
  logic    done_q;

  logic start_fire, pl_fire, out_fire;
  logic ctr_load, ctr_adv, issue;
  logic port_idle, ks_fire;
  logic ld_out, ld_mic, ld_last;
  blk_t ctr_cur, ctr_nxt, ks, ld_data;
  nb_t  nb_eff, ld_nb;

  assign start_ready = (st_q == T_IDLE);
  assign pl_ready    = (st_q == T_PL);
  assign start_fire  = start_valid && start_ready;
  assign pl_fire     = pl_valid && pl_ready;

  // Event wires
  assign ctr_load = start_fire;
  assign ctr_adv  = (st_q == T_OUT) && out_fire && !out_last;
  assign issue    = ctr_load || ctr_adv;

  ctr_counter_reg #(.CTR_BITS(CTR_BITS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(start_ctr),
    .step(ctr_adv), .ctr(ctr_cur), .ctr_next(ctr_nxt)
  );

  ctr_cipher_port u_port (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_blk(ctr_nxt),
    .idle(port_idle), .req_valid(ciph_req_valid), .req_ready(ciph_req_ready),
    .req_block(ciph_req_block), .rsp_valid(ciph_rsp_valid),
    .rsp_block(ciph_rsp_block), .ks_fire(ks_fire), .ks(ks)
  );

  // Output item formation
  assign nb_eff = norm_nbytes(pl_last, pl_nbytes);
  assign ld_mic = (st_q == T_KS) && ks_fire && mic_phase_q;
  assign ld_out = ld_mic || pl_fire;
  assign ld_last = !ld_mic && pl_last;
  assign ld_nb   = ld_mic ? MIC_NB : nb_eff;

  always_comb begin
    if (ld_mic) ld_data = {{(BLK_W-MIC_W){1'b0}}, mic_mask(mic_q, ks)};
    else        ld_data = (pl_data ^ ks) & keep_mask(nb_eff);
  end

  ctr_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .load(ld_out), .d_data(ld_data),
    .d_mic(ld_mic), .d_last(ld_last), .d_nb(ld_nb),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_is_mic(out_is_mic), .out_last(out_last), .out_nbytes(out_nbytes),
    .fire(out_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= T_IDLE;
      mic_q       <= '0;
      mic_phase_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        T_IDLE: if (start_fire) begin
          mic_q       <= start_mic;
          mic_phase_q <= 1'b1;
          st_q        <= T_KS;
        end
        T_KS: if (ks_fire) st_q <= mic_phase_q ? T_OUT : T_PL;
        T_PL: if (pl_fire) st_q <= T_OUT;
        T_OUT: if (out_fire) begin
          mic_phase_q <= 1'b0;
          if (out_last) begin
            done_q <= 1'b1;
            st_q   <= T_IDLE;
          end else begin
            st_q <= T_KS;
          end
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assign done = done_q;

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_fire && out_last));

  assert_one_block_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> (!out_valid && port_idle));

  assert_busy_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_fire) |=> !start_ready);

  assert_first_req_a0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> (ctr_cur == $past(start_ctr)));

  assert_partial_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> ((out_data & ~keep_mask(out_nbytes)) == '0));
endmodule

// File: tb/tb_ctr_mic_encryptor.sv
module tb_ctr_mic_encryptor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         start_valid = 0, start_ready;
  logic [127:0] start_ctr = '0;
  logic [63:0]  start_mic = '0;
  logic         pl_valid = 0, pl_ready, pl_last = 0;
  logic [127:0] pl_data = '0;
  logic [4:0]   pl_nbytes = '0;
  logic         ciph_req_valid, ciph_req_ready = 0;
  logic [127:0] ciph_req_block;
  logic         ciph_rsp_valid = 0;
  logic [127:0] ciph_rsp_block = '0;
  logic         out_valid, out_ready = 0, out_is_mic, out_last, done;
  logic [127:0] out_data;
  logic [4:0]   out_nbytes;

  ctr_mic_encryptor dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_ctr(start_ctr), .start_mic(start_mic), .pl_valid(pl_valid),
    .pl_ready(pl_ready), .pl_data(pl_data), .pl_last(pl_last), .pl_nbytes(pl_nbytes),
    .ciph_req_valid(ciph_req_valid), .ciph_req_ready(ciph_req_ready),
    .ciph_req_block(ciph_req_block), .ciph_rsp_valid(ciph_rsp_valid),
    .ciph_rsp_block(ciph_rsp_block), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_is_mic(out_is_mic), .out_last(out_last),
    .out_nbytes(out_nbytes), .done(done)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Stand-in block cipher, keyed by fixed constants.
  function automatic logic [127:0] bf(input logic [127:0] x);
    return ({x[100:0], x[127:101]} ^ 128'h3c5a_96e1_0f1e_2d3c_4b5a_6978_8796_a5b4)
           + {x[63:0], x[127:64]};
  endfunction

  logic [127:0] cur_a0;
  logic [63:0]  cur_t;
  int           cur_n, cur_lb;
  logic [127:0] pl_mem [0:7];
  int           ridx, oidx;
  bit           frame_done, pend_done, active;

  function automatic logic [127:0] exp_ctr(input int k);
    logic [15:0] lo;
    lo = cur_a0[15:0] + k[15:0];
    return {cur_a0[127:16], lo};
  endfunction

  function automatic int exp_nb(input int j);
    if (j == 0) return 8;
    if (j < cur_n) return 16;
    if (cur_lb == 0 || cur_lb > 16) return 16;
    return cur_lb;
  endfunction

  function automatic logic [127:0] exp_item(input int j);
    logic [127:0] m;
    if (j == 0) return {64'b0, cur_t ^ bf(cur_a0) >> 64};
    m = ~128'b0 << (8 * (16 - exp_nb(j)));
    return (pl_mem[j-1] ^ bf(exp_ctr(j))) & m;
  endfunction

  // Cipher stub
  bit pend = 0;
  int cnt = 0;
  logic [127:0] hold;
  always @(negedge clk) begin
    ciph_rsp_valid = 0;
    if (!rst_n) begin
      ciph_req_ready = 0;
      pend = 0;
    end else if (pend) begin
      ciph_req_ready = 0;
      if (cnt == 0) begin
        ciph_rsp_valid = 1;
        ciph_rsp_block = bf(hold);
        pend = 0;
      end else cnt--;
    end else begin
      ciph_req_ready = ($urandom % 3) != 0;
      if (ciph_req_valid && ciph_req_ready) begin
        if (ridx == 0)
          chk(ciph_req_block == cur_a0, "R2 first request is A0", ciph_req_block, cur_a0);
        else
          chk(ciph_req_block == exp_ctr(ridx), "R4 counter request", ciph_req_block, exp_ctr(ridx));
        hold = ciph_req_block;
        ridx++;
        pend = 1;
        cnt = $urandom % 3;
      end
    end
  end

  // Output consumer
  always @(negedge clk) begin
    bit r;
    if (pend_done) begin
      chk(done == 1'b1, "R8 done pulse", {127'b0, done}, 128'd1);
      pend_done = 0;
      frame_done = 1;
    end else if (rst_n && active) begin
      chk(done == 1'b0, "R8 no early done", {127'b0, done}, 128'd0);
    end
    r = ($urandom % 4) != 0;
    out_ready = r;
    if (rst_n && out_valid) begin
      chk(out_data == exp_item(oidx), oidx == 0 ? "R3 masked value" :
          (oidx == cur_n ? "R6 final block data" : "R5 ciphertext"), out_data, exp_item(oidx));
      chk(out_is_mic == (oidx == 0) && out_last == (oidx == cur_n),
          "R8 item flags", {126'b0, out_is_mic, out_last},
          {126'b0, oidx == 0, oidx == cur_n});
      chk(int'(out_nbytes) == exp_nb(oidx), "R6 byte count", 128'(out_nbytes),
          128'(exp_nb(oidx)));
      if (r) begin
        if (oidx == cur_n) pend_done = 1;
        oidx++;
      end
    end
  end

  task automatic run_frame(input logic [127:0] a0, input logic [63:0] t,
                           input int n, input int lb, input bit inject);
    cur_a0 = a0; cur_t = t; cur_n = n; cur_lb = lb;
    for (int i = 0; i < n; i++) pl_mem[i] = {$urandom, $urandom, $urandom, $urandom};
    ridx = 0; oidx = 0; frame_done = 0;
    @(negedge clk);
    active = 1;
    start_valid = 1; start_ctr = a0; start_mic = t;
    while (!start_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    start_valid = inject;
    start_ctr = ~a0; start_mic = ~t;
    if (inject)
      chk(start_ready == 0, "R10 busy during frame", {127'b0, start_ready}, 128'd0);
    for (int b = 0; b < n; b++) begin
      pl_valid = 1; pl_data = pl_mem[b]; pl_last = (b == n - 1);
      pl_nbytes = (b == n - 1) ? 5'(lb) : 5'($urandom % 16);
      while (!pl_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
    end
    pl_valid = 0; start_valid = 0;
    while (!frame_done) @(negedge clk);
    active = 0;
    chk(ridx == n + 1, "R7 request count", 128'(ridx), 128'(n + 1));
    chk(start_ready == 1, "R8 back to idle", {127'b0, start_ready}, 128'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c7a1));
    active = 0; pend_done = 0;
    repeat (3) @(negedge clk);
    chk(start_ready == 1 && out_valid == 0 && ciph_req_valid == 0 && pl_ready == 0
        && done == 0, "R1 reset state",
        {123'b0, start_ready, out_valid, ciph_req_valid, pl_ready, done}, 128'h10);
    rst_n = 1;
    run_frame(128'h0011_2233_4455_6677_8899_aabb_ccdd_0001, 64'hfeed_beef_0123_4567, 1, 16, 0);
    run_frame(128'h1234_5678_9abc_def0_0fed_cba9_8765_0010, 64'h0, 2, 1, 0);
    run_frame(128'hcafe_0000_1111_2222_3333_4444_5555_fffe, 64'h1357_9bdf_2468_ace0, 3, 15, 1);
    run_frame(128'hffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 2, 7, 0);
    run_frame(128'h0, 64'h55aa_55aa_55aa_55aa, 3, 0, 1);
    run_frame(128'h8000_0000_0000_0000_0000_0000_0000_7fff, 64'h1, 1, 20, 0);
    for (int f = 0; f < 24; f++) begin
      logic [127:0] a;
      a = {$urandom, $urandom, $urandom, $urandom};
      if (f % 3 == 0) a[15:0] = 16'hffff - 16'($urandom % 4);
      run_frame(a, {$urandom, $urandom}, 1 + ($urandom % 6), $urandom % 18, (f % 4) == 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule